// File: doc/BRIEF.md
# Key-Gated Diagnostic Access Window

This block places a Dword-wide diagnostic data window onto an internal bus behind a software unlock. The host first writes a candidate key into an unlock register. If the value equals the key parameter, an unlock flag is set. Any other value written there clears the flag. The flag can be read in a status register, and host writes cannot change it directly. A separate address register holds the internal-bus address, forced to Dword alignment, that data-window accesses use.

The data window works only for accesses that arrive through the I/O-space aperture, which the `reg_io` input marks. An I/O-space read of the window starts an internal-bus read, and the register port stalls until the bus responds. If the bus stays silent past a bounded wait, the read completes with all ones. An I/O-space write of the window reaches the bus only while the unlock flag is set; otherwise it is dropped. Memory-space accesses to the window read all ones, never touch the bus and change nothing.

Top module: `diag_window`

## Requirements
- R1: After reset the unlock flag is 0, the address register holds 0, and `reg_ack` and `bus_req` are low.
- R2: An accepted write of exactly the `KEY` parameter to offset 0 (unlock register) sets the unlock flag, which reads back as bit 0 of offset 1 (status register). Every other status bit reads 0.
- R3: An accepted write of any other value to offset 0 clears the unlock flag.
- R4: A host write to offset 1 has no effect on the unlock flag.
- R5: A memory-space (`reg_io`=0) read of offset 3 (data window) returns 0xFFFFFFFF. It raises no bus request, and `reg_ack` pulses for one cycle on the clock edge after the request is first sampled.
- R6: A memory-space write of offset 3 raises no bus request and is acknowledged on the next edge.
- R7: An I/O-space write of offset 3 while the unlock flag is 0 raises no bus request and is acknowledged on the next edge.
- R8: An I/O-space write of offset 3 while unlocked issues one bus request with `bus_we`=1 and the written data. Its `bus_addr` equals offset 2 (address register) with bits [1:0] cleared. `reg_ack` pulses on the edge after `bus_rsp` is sampled high.
- R9: An I/O-space read of offset 3, locked or unlocked, issues a bus request with `bus_we`=0 and stalls the port. On the edge after `bus_rsp` is sampled high, `reg_ack` pulses and `reg_rdata` carries `bus_rdata`.
- R10: If `bus_rsp` does not arrive within `TIMEOUT` cycles of the request being raised, the request is withdrawn. `reg_ack` then pulses with `reg_rdata` = 0xFFFFFFFF.
- R11: Offset 2 is readable and writable in either space and reads back the last value written.
- R12: While `bus_req` is held, `bus_addr`, `bus_we` and `bus_wdata` stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req | input | 1 | Register access request, held until `reg_ack` |
| reg_io | input | 1 | 1 = I/O-space aperture, 0 = memory-space aperture |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Register offset: 0 unlock, 1 status, 2 address, 3 data window |
| reg_wdata | input | 32 | Write data |
| reg_ack | output | 1 | One-cycle completion pulse |
| reg_rdata | output | 32 | Read data, valid with `reg_ack` |
| bus_req | output | 1 | Internal-bus request, held until response or timeout |
| bus_we | output | 1 | Internal-bus write strobe |
| bus_addr | output | BUS_AW | Dword-aligned internal-bus address |
| bus_wdata | output | 32 | Internal-bus write data |
| bus_rsp | input | 1 | Internal-bus response pulse |
| bus_rdata | input | 32 | Internal-bus read data, valid with `bus_rsp` |

## Verification
The unlock register is driven with a wrong value, the key, the key again, and writes to the status register. This shows that only an exact match sets the flag and that the status register is read-only. The data window is hit with every mix of aperture, direction and lock state. Separating memory-space reads, locked I/O writes and unlocked I/O writes shows where the bus must stay quiet. The bus responder answers after 0, 2, 3 and 5 cycles and, in one case, never. The measured acknowledge delay tells a true stall from an early completion. The silent case tells a timeout from a hang.

// File: rtl/diag_window_pkg.sv
package diag_window_pkg;

    localparam int DWORD_W = 32;

    typedef enum logic [1:0] {
        SEL_UNLOCK = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_ADDR   = 2'd2,
        SEL_DATA   = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_WAIT = 1'b1
    } eng_state_e;

endpackage

// File: rtl/diag_key_gate.sv
module diag_key_gate #(
    parameter int               KEY_W = 32,
    parameter logic [KEY_W-1:0] KEY   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seq_wr,
    input  logic [KEY_W-1:0] seq_data,
    output logic             unlocked
);

    typedef struct packed {
        logic open;
    } gate_t;

    gate_t gate_d, gate_q;

    always_comb begin
        gate_d = gate_q;
        if (seq_wr) begin
            gate_d.open = (seq_data == KEY);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= '0;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign unlocked = gate_q.open;

endmodule

// File: rtl/diag_bus_engine.sv
module diag_bus_engine
    import diag_window_pkg::*;
#(
    parameter int BUS_AW  = 32,
    parameter int TIMEOUT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               start_we,
    input  logic [BUS_AW-1:0]  start_addr,
    input  logic [DWORD_W-1:0] start_wdata,
    output logic               busy,
    output logic               done,
    output logic [DWORD_W-1:0] done_rdata,
    output logic               bus_req,
    output logic               bus_we,
    output logic [BUS_AW-1:0]  bus_addr,
    output logic [DWORD_W-1:0] bus_wdata,
    input  logic               bus_rsp,
    input  logic [DWORD_W-1:0] bus_rdata
);

    localparam int CNT_W = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

    typedef struct packed {
        eng_state_e         st;
        logic [CNT_W-1:0]   cnt;
        logic               req;
        logic               we;
        logic [BUS_AW-1:0]  addr;
        logic [DWORD_W-1:0] wdata;
        logic               done;
        logic [DWORD_W-1:0] rdata;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        unique case (eng_q.st)
            ENG_IDLE: begin
                if (start) begin
                    eng_d.st    = ENG_WAIT;
                    eng_d.req   = 1'b1;
                    eng_d.we    = start_we;
                    eng_d.addr  = start_addr;
                    eng_d.wdata = start_wdata;
                    eng_d.cnt   = '0;
                end
            end
            ENG_WAIT: begin
                if (bus_rsp) begin
                    eng_d.st    = ENG_IDLE;
                    eng_d.req   = 1'b0;
                    eng_d.done  = 1'b1;
                    eng_d.rdata = eng_q.we ? '0 : bus_rdata;
                end else if (eng_q.cnt == CNT_LAST) begin
                    eng_d.st    = ENG_IDLE;
                    eng_d.req   = 1'b0;
                    eng_d.done  = 1'b1;
                    eng_d.rdata = '1;
                end else begin
                    eng_d.cnt = eng_q.cnt + 1'b1;
                end
            end
            default: eng_d = eng_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign busy       = (eng_q.st == ENG_WAIT);
    assign done       = eng_q.done;
    assign done_rdata = eng_q.rdata;
    assign bus_req    = eng_q.req;
    assign bus_we     = eng_q.we;
    assign bus_addr   = eng_q.addr;
    assign bus_wdata  = eng_q.wdata;

endmodule

// File: rtl/diag_window.sv
module diag_window
    import diag_window_pkg::*;
#(
    parameter logic [31:0] KEY     = 32'hA5C3_0F96,
    parameter int          BUS_AW  = 32,
    parameter int          TIMEOUT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_req,
    input  logic               reg_io,
    input  logic               reg_we,
    input  logic [1:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic               reg_ack,
    output logic [31:0]        reg_rdata,
    output logic               bus_req,
    output logic               bus_we,
    output logic [BUS_AW-1:0]  bus_addr,
    output logic [31:0]        bus_wdata,
    input  logic               bus_rsp,
    input  logic [31:0]        bus_rdata
);

    typedef struct packed {
        logic               ack;
        logic [DWORD_W-1:0] rdata;
        logic [BUS_AW-1:0]  daddr;
    } port_t;

    port_t port_d, port_q;

    logic               unlocked;
    logic               eng_busy;
    logic               eng_done;
    logic [DWORD_W-1:0] eng_rdata;
    logic               accept;
    logic               key_wr;
    logic               eng_start;
    logic [BUS_AW-1:0]  aligned_addr;
    reg_sel_e           sel;

    assign sel          = reg_sel_e'(reg_addr);
    assign accept       = reg_req && !eng_busy && !reg_ack;
    assign aligned_addr = {port_q.daddr[BUS_AW-1:2], 2'b00};

    always_comb begin
        port_d     = port_q;
        port_d.ack = 1'b0;
        key_wr     = 1'b0;
        eng_start  = 1'b0;
        if (accept) begin
            unique case (sel)
                SEL_UNLOCK: begin
                    key_wr       = reg_we;
                    port_d.ack   = 1'b1;
                    port_d.rdata = '0;
                end
                SEL_STATUS: begin
                    port_d.ack   = 1'b1;
                    port_d.rdata = {{(DWORD_W-1){1'b0}}, unlocked};
                end
                SEL_ADDR: begin
                    port_d.ack   = 1'b1;
                    port_d.rdata = DWORD_W'(port_q.daddr);
                    if (reg_we) begin
                        port_d.daddr = reg_wdata[BUS_AW-1:0];
                    end
                end
                SEL_DATA: begin
                    if (!reg_io) begin
                        port_d.ack   = 1'b1;
                        port_d.rdata = '1;
                    end else if (!reg_we || unlocked) begin
                        eng_start = 1'b1;
                    end else begin
                        port_d.ack   = 1'b1;
                        port_d.rdata = '0;
                    end
                end
                default: port_d = port_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q <= '0;
        end else begin
            port_q <= port_d;
        end
    end

    diag_key_gate #(
        .KEY_W (32),
        .KEY   (KEY)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .seq_wr   (key_wr),
        .seq_data (reg_wdata),
        .unlocked (unlocked)
    );

    diag_bus_engine #(
        .BUS_AW  (BUS_AW),
        .TIMEOUT (TIMEOUT)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (eng_start),
        .start_we    (reg_we),
        .start_addr  (aligned_addr),
        .start_wdata (reg_wdata),
        .busy        (eng_busy),
        .done        (eng_done),
        .done_rdata  (eng_rdata),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rsp     (bus_rsp),
        .bus_rdata   (bus_rdata)
    );

    assign reg_ack   = port_q.ack | eng_done;
    assign reg_rdata = eng_done ? eng_rdata : port_q.rdata;

endmodule

// File: rtl/diag_window_chk.sv
module diag_window_chk #(
    parameter logic [31:0] KEY    = 32'hA5C3_0F96,
    parameter int          BUS_AW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_io,
    input logic              reg_we,
    input logic [1:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              reg_ack,
    input logic [31:0]       reg_rdata,
    input logic              bus_req,
    input logic              bus_we,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_rsp,
    input logic [31:0]       bus_rdata,
    input logic              unlocked,
    input logic              accept
);

    // R5 R6
    bus_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(accept && reg_io && reg_addr == 2'd3));

    // R7
    locked_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_req) && bus_we) |-> $past(unlocked));

    // R2 R3
    key_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && reg_we && reg_addr == 2'd0) |=> (unlocked == $past(reg_wdata == KEY)));

    // R4
    status_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && reg_addr != 2'd0) |=> $stable(unlocked));

    // R8
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_addr[1:0] == 2'b00));

    // R12
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && $past(bus_req)) |-> ($stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    // R9
    rd_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_ack && $past(bus_req && bus_rsp && !bus_we)) |-> (reg_rdata == $past(bus_rdata)));

    // R10
    timeout_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_ack && $past(bus_req && !bus_rsp)) |-> (reg_rdata == 32'hFFFF_FFFF));

    // R5
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_ack |=> !reg_ack);

endmodule

bind diag_window diag_window_chk #(
    .KEY    (KEY),
    .BUS_AW (BUS_AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_io    (reg_io),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_ack   (reg_ack),
    .reg_rdata (reg_rdata),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rsp   (bus_rsp),
    .bus_rdata (bus_rdata),
    .unlocked  (unlocked),
    .accept    (accept)
);

// File: tb/test_diag_window.sv
`timescale 1ns/1ps
module test_diag_window;

    localparam logic [31:0] KEY     = 32'hA5C3_0F96;
    localparam int          TIMEOUT = 16;
    localparam logic [31:0] SCRAM   = 32'h5A5A_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 1'b0, reg_io = 1'b0, reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_ack;
    logic [31:0] reg_rdata;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic        bus_rsp = 1'b0;
    logic [31:0] bus_rdata = '0;

    always #2.5 clk = ~clk;

    diag_window #(.KEY(KEY), .BUS_AW(32), .TIMEOUT(TIMEOUT)) i_diag_window (
        .clk(clk), .rst_n(rst_n),
        .reg_req(reg_req), .reg_io(reg_io), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rsp(bus_rsp), .bus_rdata(bus_rdata)
    );

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [31:0] exp;
        bit          cmp;
        string       tag;
    } rd_item_t;

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
        string       tag;
    } bus_item_t;

    rd_item_t  rd_q[$];
    bus_item_t bus_q[$];

    int  rsp_lat = 0;
    bit  rsp_mute = 1'b0;
    bit  rsp_active = 1'b0;
    int  rsp_cnt = 0;
    bit  prev_req = 1'b0;
    logic [31:0] held_addr;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Register-port monitor: pops expected read data on each acknowledge
    always @(negedge clk) begin
        if (rst_n && reg_ack) begin
            if (rd_q.size() == 0) begin
                check(1'b0, "R5 unexpected ack", 32'(reg_ack), 32'd0);
            end else begin
                rd_item_t it;
                it = rd_q.pop_front();
                if (it.cmp) check(reg_rdata === it.exp, it.tag, reg_rdata, it.exp);
            end
        end
    end

    // Internal-bus responder and monitor
    always @(negedge clk) begin
        if (bus_rsp) begin
            bus_rsp = 1'b0;
        end else if (rst_n) begin
            if (bus_req && !prev_req) begin
                if (bus_q.size() == 0) begin
                    check(1'b0, "R6 R7 unexpected bus request", bus_addr, 32'd0);
                end else begin
                    bus_item_t b;
                    b = bus_q.pop_front();
                    check(bus_we === b.we && bus_addr === b.addr &&
                          (!b.we || bus_wdata === b.wdata), b.tag, bus_addr, b.addr);
                end
                held_addr = bus_addr;
                if (!rsp_mute) begin
                    rsp_active = 1'b1;
                    rsp_cnt    = rsp_lat;
                end
            end
            if (rsp_active) begin
                check(bus_req === 1'b1 && bus_addr === held_addr, "R12 bus request held", bus_addr, held_addr);
                if (rsp_cnt == 0) begin
                    bus_rsp    = 1'b1;
                    bus_rdata  = bus_addr ^ SCRAM;
                    rsp_active = 1'b0;
                end else begin
                    rsp_cnt--;
                end
            end
        end
        prev_req = bus_req;
    end

    // Driver: pushes expectations, runs one access, checks acknowledge delay
    task automatic access(input bit io, input bit we, input logic [1:0] a, input logic [31:0] wd,
                          input logic [31:0] exp, input bit cmp, input int wait_exp, input string tag);
        rd_item_t it;
        int n;
        it.exp = exp; it.cmp = cmp; it.tag = tag;
        rd_q.push_back(it);
        @(negedge clk);
        reg_req = 1'b1; reg_io = io; reg_we = we; reg_addr = a; reg_wdata = wd;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!reg_ack);
        reg_req = 1'b0;
        check(n == wait_exp, {tag, " ack delay"}, 32'(n), 32'(wait_exp));
    endtask

    task automatic expect_bus(input logic we, input logic [31:0] a, input logic [31:0] wd, input string tag);
        bus_item_t b;
        b.we = we; b.addr = a; b.wdata = wd; b.tag = tag;
        bus_q.push_back(b);
    endtask

    task automatic finish_run();
        check(bus_q.size() == 0, "R8 R9 all bus requests seen", 32'(bus_q.size()), 32'd0);
        check(rd_q.size() == 0, "R5 all acks seen", 32'(rd_q.size()), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            check(1'b0, "watchdog expired", 32'(cyc), 32'd0);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(reg_ack === 1'b0, "R1 ack low in reset", 32'(reg_ack), 32'd0);
        check(bus_req === 1'b0, "R1 bus_req low in reset", 32'(bus_req), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(reg_ack === 1'b0 && bus_req === 1'b0, "R1 idle after reset", 32'(reg_ack), 32'd0);

        access(1, 0, 2'd1, 0, 32'd0, 1, 1, "R1 status after reset");
        access(0, 0, 2'd2, 0, 32'd0, 1, 1, "R1 address reg after reset");

        // R11 address register both spaces
        access(1, 1, 2'd2, 32'h1000_0013, 0, 0, 1, "R11 addr write io");
        access(0, 0, 2'd2, 0, 32'h1000_0013, 1, 1, "R11 addr readback mem");

        // R7 locked I/O write dropped
        access(1, 1, 2'd3, 32'hDEAD_BEEF, 0, 0, 1, "R7 locked io write");

        // R2 R3 R4 unlock sequence
        access(1, 1, 2'd0, KEY ^ 32'h1, 0, 0, 1, "R3 wrong key");
        access(1, 0, 2'd1, 0, 32'd0, 1, 1, "R3 status after wrong key");
        access(0, 1, 2'd0, KEY, 0, 0, 1, "R2 key write");
        access(1, 0, 2'd1, 0, 32'd1, 1, 1, "R2 status after key");
        access(1, 1, 2'd1, 32'h0, 0, 0, 1, "R4 status write");
        access(1, 0, 2'd1, 0, 32'd1, 1, 1, "R4 status unchanged by write");
        access(1, 1, 2'd0, 32'h0, 0, 0, 1, "R3 zero key");
        access(1, 0, 2'd1, 0, 32'd0, 1, 1, "R3 status cleared");
        access(1, 1, 2'd0, KEY, 0, 0, 1, "R2 key again");
        access(1, 0, 2'd1, 0, 32'd1, 1, 1, "R2 status set again");

        // R5 R6 memory space on data window
        access(0, 1, 2'd3, 32'h1234_5678, 0, 0, 1, "R6 mem write dropped");
        access(0, 0, 2'd3, 0, 32'hFFFF_FFFF, 1, 1, "R5 mem read all ones");

        // R8 unlocked writes at two latencies
        rsp_lat = 0;
        expect_bus(1, 32'h1000_0010, 32'hCAFE_0001, "R8 bus write lat0");
        access(1, 1, 2'd3, 32'hCAFE_0001, 0, 0, 2, "R8 io write lat0");
        rsp_lat = 3;
        expect_bus(1, 32'h1000_0010, 32'hCAFE_0002, "R8 bus write lat3");
        access(1, 1, 2'd3, 32'hCAFE_0002, 0, 0, 5, "R8 io write lat3");

        // R9 reads at several latencies and addresses
        rsp_lat = 2;
        expect_bus(0, 32'h1000_0010, 0, "R9 bus read lat2");
        access(1, 0, 2'd3, 0, 32'h1000_0010 ^ SCRAM, 1, 4, "R9 io read lat2");
        access(1, 1, 2'd2, 32'h0000_ABCF, 0, 0, 1, "R11 addr rewrite");
        rsp_lat = 5;
        expect_bus(0, 32'h0000_ABCC, 0, "R9 bus read lat5");
        access(1, 0, 2'd3, 0, 32'h0000_ABCC ^ SCRAM, 1, 7, "R9 io read lat5");

        // R9 read while locked still reaches the bus
        access(1, 1, 2'd0, 32'h5, 0, 0, 1, "R3 relock");
        rsp_lat = 0;
        expect_bus(0, 32'h0000_ABCC, 0, "R9 bus read locked");
        access(1, 0, 2'd3, 0, 32'h0000_ABCC ^ SCRAM, 1, 2, "R9 io read locked");
        access(1, 1, 2'd3, 32'h7777_7777, 0, 0, 1, "R7 locked io write again");

        // R10 silent bus
        rsp_mute = 1'b1;
        expect_bus(0, 32'h0000_ABCC, 0, "R10 bus read silent");
        access(1, 0, 2'd3, 0, 32'hFFFF_FFFF, 1, TIMEOUT + 1, "R10 timeout read");
        check(bus_req === 1'b0, "R10 request withdrawn", 32'(bus_req), 32'd0);
        rsp_mute = 1'b0;
        rsp_lat = 1;
        expect_bus(0, 32'h0000_ABCC, 0, "R10 bus read after timeout");
        access(1, 0, 2'd3, 0, 32'h0000_ABCC ^ SCRAM, 1, 3, "R10 recovery read");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule